// File: doc/BRIEF.md
# Dual-Output Interrupt Router

This block gathers up to 64 interrupt sources and presents them to a processor core on two request lines: a normal request and a fast request. Every source has a pending bit. A level-sensitive source's pending bit follows the input, with an active level set per source. An edge-sensitive source's pending bit is set by a transition and stays set until software clears it. A pending source raises a request only while its enable bit is set. A per-source routing bit then steers it to the fast line (bit = 1) or the normal line (bit = 0).

Software reaches the block over a 32-bit register bus. Writes are single-cycle strobes and reads are combinational. Every 64-bit control vector is seen as two 32-bit words. Byte-address bit 2 picks the upper word (sources 32..63). Bits 1:0 must be zero for a write to land. The bits above bit 2 pick the register.

The register window starts at parameter `WIN_BASE`, which is 0x80 by default. Addresses below it form an older register set. That set is decoded but never changes any state. Word offsets within the window are:

| Offset | Register |
|---|---|
| 0x00 | normal-request status |
| 0x08 | fast-request status |
| 0x10 | pending |
| 0x18 | routing |
| 0x20 | enable set |
| 0x28 | enable clear |
| 0x30 | software set |
| 0x38 | software clear |
| 0x40 | sensitivity |
| 0x48 | dual-edge |
| 0x50 | polarity |
| 0x58 | edge clear |
| 0x60 | edge status |

Sensitivity (1 = level), dual-edge and reset polarity are parameters. Only the four highest sources can have their polarity changed at run time.

Top module: `vic_dual_route`

## Requirements
- R1: After reset the enable, routing and pending vectors are zero and both request outputs are low. Reading sensitivity (offset 0x40) returns the `SENSE_INIT` parameter. Reading dual-edge (0x48) returns the `BOTH_INIT` parameter. Reading polarity (0x50) returns the `EVENT_INIT` parameter.
- R2: A read returns the 32-bit word that byte-address bit 2 selects: the lower word (sources 0..31) when bit 2 is 0, and the upper word (sources 32..63) when bit 2 is 1. On a write, bit 2 places the data on the same half.
- R3: A write to routing (0x18) replaces only the addressed word. The other word keeps its value.
- R4: A write to enable set (0x20) ORs the data into the enable vector. A write to enable clear (0x28) clears every enable bit where the data holds a one. Reading either offset returns the enable vector.
- R5: The normal status (0x00) is pending AND enable AND NOT routing. The fast status (0x08) is pending AND enable AND routing. `irq_o` and `fiq_o` are the OR of the normal and fast status respectively, and they change right after the clock edge that updates the state.
- R6: An edge-sensitive source sets its pending bit on the clock edge after its input transition. A source with polarity 1 captures a rising transition. A source with polarity 0 captures a falling transition. A source whose dual-edge bit is set captures either transition. The pending bit then stays set until it is cleared.
- R7: A level-sensitive pending bit equals (input == polarity bit), sampled once per clock. So polarity 1 means active high and polarity 0 means active low.
- R8: A write to edge clear (0x58) clears the pending bits at the data's ones, but only for edge-sensitive sources. Level-sensitive pending bits are unaffected. A transition captured on the same clock edge as the clear wins over the clear.
- R9: Only the four highest polarity bits (sources NSRC-4..NSRC-1, upper-word bits 28..31 by default) can be written, through the upper word. All other polarity bits keep their reset value. A write to the lower word of the polarity register changes nothing.
- R10: A write below `WIN_BASE` changes no state and raises no request.
- R11: Writes to normal status, fast status, pending, sensitivity, dual-edge, edge status, software set, software clear, or any offset beyond 0x64 change no state and raise no request.
- R12: Edge status (0x60) reads pending AND NOT sensitivity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NSRC | Interrupt source inputs |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions watch, on every clock, these properties of the register state:
- An enable set leaves the written bits set, and an enable clear leaves them cleared.
- A routing write to the lower word never disturbs the upper word.
- A polarity write to the lower word leaves polarity untouched.
- A captured edge stays pending until a clear strobe reaches it.
- Legacy, read-only and undefined writes leave routing, enable and polarity stable.

Only the directed scenarios can show that the right events are captured at all. These are:
- rising, falling and dual-edge capture, and active-low level tracking;
- the same-cycle race between an edge and its clear;
- the exact values seen on the status words, the parameter readbacks and the two request pins after routing changes.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [3:0] {
      RG_IRQ_STAT  = 4'd0,
      RG_FIQ_STAT  = 4'd1,
      RG_PEND      = 4'd2,
      RG_ROUTE     = 4'd3,
      RG_EN_SET    = 4'd4,
      RG_EN_CLR    = 4'd5,
      RG_SW_SET    = 4'd6,
      RG_SW_CLR    = 4'd7,
      RG_SENSE     = 4'd8,
      RG_DUAL      = 4'd9,
      RG_POL       = 4'd10,
      RG_EDGE_CLR  = 4'd11,
      RG_EDGE_STAT = 4'd12,
      RG_NONE      = 4'd15
   } vic_reg_e;

   localparam int unsigned LAST_REG = 12;

   typedef struct packed {
      logic     legacy;
      logic     hit;
      logic     upper;
      vic_reg_e rsel;
   } vic_dec_t;

   function automatic logic [63:0] place_word(input logic upper, input logic [31:0] d);
      return upper ? {d, 32'h0} : {32'h0, d};
   endfunction

   function automatic logic [31:0] pick_word(input logic upper, input logic [63:0] v);
      return upper ? v[63:32] : v[31:0];
   endfunction

endpackage

// File: rtl/vic_addr_dec.sv
module vic_addr_dec
   import vic_pkg::*;
#(
   parameter int unsigned     AW       = 8,
   parameter logic [AW-1:0]   WIN_BASE = 8'h80
) (
   input  logic [AW-1:0] addr,
   output vic_dec_t      dec
);
   localparam int unsigned     IW       = AW - 3;
   localparam logic [IW-1:0]   LAST_IDX = LAST_REG[IW-1:0];

   logic [AW-1:0] off;
   logic [IW-1:0] idx;

   always_comb begin
      off        = addr - WIN_BASE;
      idx        = off[AW-1:3];
      dec.legacy = (addr < WIN_BASE);
      dec.upper  = addr[2];
      dec.hit    = !dec.legacy && (addr[1:0] == 2'b00) && (idx <= LAST_IDX);
      dec.rsel   = dec.hit ? vic_reg_e'(4'(idx)) : RG_NONE;
   end
endmodule

// File: rtl/vic_ctrl_regs.sv
module vic_ctrl_regs
   import vic_pkg::*;
#(
   parameter int unsigned NSRC       = 64,
   parameter logic [63:0] EVENT_INIT = '1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  vic_reg_e    rsel,
   input  logic        upper,
   input  logic [63:0] wd,
   output logic [63:0] sel_q,
   output logic [63:0] en_q,
   output logic [63:0] ev_q
);
   localparam logic [63:0] VALID    = {64{1'b1}} >> (64 - NSRC);
   localparam logic [63:0] EV_WMASK = 64'hF << (NSRC - 4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= '0;
         ev_q  <= EVENT_INIT & VALID;
      end else if (wr) begin
         case (rsel)
            RG_ROUTE:  sel_q <= upper ? {wd[63:32], sel_q[31:0]} : {sel_q[63:32], wd[31:0]};
            RG_EN_SET: en_q  <= en_q | wd;
            RG_EN_CLR: en_q  <= en_q & ~wd;
            RG_POL:    if (upper) ev_q <= (ev_q & ~EV_WMASK) | (wd & EV_WMASK);
            default:   ;
         endcase
      end
   end

   a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr && rsel == RG_EN_SET |=> ((en_q & $past(wd)) == $past(wd)));

   a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
      wr && rsel == RG_EN_CLR |=> ((en_q & $past(wd)) == 64'h0));

   a_r3_route_half: assert property (@(posedge clk) disable iff (!rst_n)
      wr && rsel == RG_ROUTE && !upper |=> $stable(sel_q[63:32]));

   a_r9_pol_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      wr && rsel == RG_POL && !upper |=> $stable(ev_q));
endmodule

// File: rtl/vic_raw_latch.sv
module vic_raw_latch #(
   parameter int unsigned NSRC       = 64,
   parameter logic [63:0] SENSE_INIT = '0,
   parameter logic [63:0] BOTH_INIT  = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [NSRC-1:0] pol,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] raw
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic raw_r;
      assign raw[i] = raw_r;

      if (SENSE_INIT[i]) begin : g_level
         logic unused_clr;
         assign unused_clr = clr[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) raw_r <= 1'b0;
            else        raw_r <= (src[i] == pol[i]);
         end
      end else begin : g_edge
         logic prev_q;
         logic fire;
         if (BOTH_INIT[i]) begin : g_dual
            logic unused_pol;
            assign unused_pol = pol[i];
            assign fire = src[i] ^ prev_q;
         end else begin : g_single
            assign fire = pol[i] ? (src[i] & ~prev_q) : (~src[i] & prev_q);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               raw_r  <= 1'b0;
            end else begin
               prev_q <= src[i];
               raw_r  <= fire | (raw_r & ~clr[i]);
            end
         end

         a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            raw_r && !clr[i] |=> raw_r);
      end
   end
endmodule

// File: rtl/vic_dual_route.sv
module vic_dual_route
   import vic_pkg::*;
#(
   parameter int unsigned   NSRC       = 64,
   parameter int unsigned   AW         = 8,
   parameter logic [AW-1:0] WIN_BASE   = 8'h80,
   parameter logic [63:0]   SENSE_INIT = 64'h0000_0000_0000_FFFF,
   parameter logic [63:0]   BOTH_INIT  = 64'h8000_0000_0000_0000,
   parameter logic [63:0]   EVENT_INIT = 64'hBFFF_FFFF_FFFF_FFFD
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   input  logic [AW-1:0]   bus_addr,
   input  logic            bus_wr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            irq_o,
   output logic            fiq_o
);
   localparam logic [63:0] VALID = {64{1'b1}} >> (64 - NSRC);
   localparam logic [63:0] SENSE = SENSE_INIT & VALID;
   localparam logic [63:0] DUAL  = BOTH_INIT & VALID;

   if (NSRC < 36 || NSRC > 64) begin : g_bad_nsrc
      $error("NSRC must lie in 36..64");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (WIN_BASE[2:0] != 3'b000) begin : g_bad_base
      $error("WIN_BASE must be 8-byte aligned");
   end

   vic_dec_t    dec;
   logic        wr_hit;
   logic [63:0] wd64;
   logic [63:0] sel_q, en_q, ev_q;
   logic [63:0] clr64, raw64;
   logic [NSRC-1:0] raw_n;
   logic [63:0] irq_stat, fiq_stat;

   vic_addr_dec #(.AW(AW), .WIN_BASE(WIN_BASE)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   assign wr_hit = bus_wr && dec.hit;
   assign wd64   = place_word(dec.upper, bus_wdata) & VALID;

   vic_ctrl_regs #(.NSRC(NSRC), .EVENT_INIT(EVENT_INIT)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_hit),
      .rsel  (dec.rsel),
      .upper (dec.upper),
      .wd    (wd64),
      .sel_q (sel_q),
      .en_q  (en_q),
      .ev_q  (ev_q)
   );

   assign clr64 = (wr_hit && dec.rsel == RG_EDGE_CLR) ? (wd64 & ~SENSE) : 64'h0;

   vic_raw_latch #(.NSRC(NSRC), .SENSE_INIT(SENSE), .BOTH_INIT(DUAL)) u_raw (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_in),
      .pol   (ev_q[NSRC-1:0]),
      .clr   (clr64[NSRC-1:0]),
      .raw   (raw_n)
   );

   assign raw64    = 64'(raw_n);
   assign irq_stat = raw64 & en_q & ~sel_q;
   assign fiq_stat = raw64 & en_q & sel_q;
   assign irq_o    = |irq_stat;
   assign fiq_o    = |fiq_stat;

   always_comb begin
      case (dec.rsel)
         RG_IRQ_STAT:          bus_rdata = pick_word(dec.upper, irq_stat);
         RG_FIQ_STAT:          bus_rdata = pick_word(dec.upper, fiq_stat);
         RG_PEND:              bus_rdata = pick_word(dec.upper, raw64);
         RG_ROUTE:             bus_rdata = pick_word(dec.upper, sel_q);
         RG_EN_SET, RG_EN_CLR: bus_rdata = pick_word(dec.upper, en_q);
         RG_SENSE:             bus_rdata = pick_word(dec.upper, SENSE);
         RG_DUAL:              bus_rdata = pick_word(dec.upper, DUAL);
         RG_POL:               bus_rdata = pick_word(dec.upper, ev_q);
         RG_EDGE_STAT:         bus_rdata = pick_word(dec.upper, raw64 & ~SENSE);
         default:              bus_rdata = 32'h0;
      endcase
   end

   a_r10_legacy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && dec.legacy |=> $stable(sel_q) && $stable(en_q) && $stable(ev_q));

   a_r11_readonly_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (dec.rsel inside {RG_IRQ_STAT, RG_FIQ_STAT, RG_PEND, RG_SENSE, RG_DUAL,
                                  RG_EDGE_STAT, RG_SW_SET, RG_SW_CLR, RG_NONE})
      |=> $stable(sel_q) && $stable(en_q) && $stable(ev_q));
endmodule

// File: tb/vic_dual_route_bench.sv
`timescale 1ns/1ps
module vic_dual_route_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_in = 64'h2;
   logic [7:0]  bus_addr = 8'h0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vic_dual_route u_vic_dual_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .fiq_o     (fiq_o)
   );

   // word addresses, default window at 0x80
   localparam logic [7:0] A_IRQ = 8'h80, A_FIQ = 8'h88, A_PEND = 8'h90, A_ROUTE = 8'h98,
                          A_ENS = 8'hA0, A_ENC = 8'hA8, A_SWS = 8'hB0, A_SWC = 8'hB8,
                          A_SENSE = 8'hC0, A_DUAL = 8'hC8, A_POL = 8'hD0, A_ECLR = 8'hD8,
                          A_ESTAT = 8'hE0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_src(input int i, input logic v);
      @(negedge clk);
      src_in[i] = v;
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1 irq_o", {31'h0, irq_o}, 32'h0);
      check("R1 fiq_o", {31'h0, fiq_o}, 32'h0);
      rd(A_ROUTE, d);       check("R1 route lo", d, 32'h0);
      rd(A_ENS + 8'h4, d);  check("R1 enable hi", d, 32'h0);
      rd(A_PEND, d);        check("R1 pending lo", d, 32'h0);
      rd(A_SENSE, d);       check("R1 sense lo", d, 32'h0000_FFFF);
      rd(A_DUAL + 8'h4, d); check("R1 R2 dual hi", d, 32'h8000_0000);
      rd(A_POL + 8'h4, d);  check("R1 R2 polarity hi", d, 32'hBFFF_FFFF);
      rd(A_POL, d);         check("R1 R2 polarity lo", d, 32'hFFFF_FFFD);
   endtask

   task automatic t_level;
      logic [31:0] d;
      set_src(0, 1'b1);
      rd(A_PEND, d); check("R7 active-high level set", d, 32'h1);
      wr(A_ECLR, 32'h1);
      rd(A_PEND, d); check("R8 level not cleared", d, 32'h1);
      set_src(0, 1'b0);
      rd(A_PEND, d); check("R7 level follows input", d, 32'h0);
      set_src(1, 1'b0);
      rd(A_PEND, d); check("R7 active-low level", d, 32'h2);
      set_src(1, 1'b1);
      rd(A_PEND, d); check("R7 active-low release", d, 32'h0);
   endtask

   task automatic t_edge;
      logic [31:0] d;
      set_src(20, 1'b1);
      rd(A_PEND, d);  check("R6 rising capture", d, 32'h0010_0000);
      set_src(20, 1'b0);
      rd(A_PEND, d);  check("R6 edge held", d, 32'h0010_0000);
      rd(A_ESTAT, d); check("R12 edge status", d, 32'h0010_0000);
      wr(A_ECLR, 32'h0010_0000);
      rd(A_PEND, d);  check("R8 edge cleared", d, 32'h0);
      set_src(62, 1'b1);
      rd(A_PEND + 8'h4, d); check("R6 falling source ignores rise", d, 32'h0);
      set_src(62, 1'b0);
      rd(A_PEND + 8'h4, d); check("R6 falling capture", d, 32'h4000_0000);
      wr(A_ECLR + 8'h4, 32'h4000_0000);
      set_src(63, 1'b1);
      rd(A_PEND + 8'h4, d); check("R6 dual rise", d, 32'h8000_0000);
      wr(A_ECLR + 8'h4, 32'h8000_0000);
      rd(A_PEND + 8'h4, d); check("R8 dual cleared", d, 32'h0);
      set_src(63, 1'b0);
      rd(A_PEND + 8'h4, d); check("R6 dual fall", d, 32'h8000_0000);
      wr(A_ECLR + 8'h4, 32'h8000_0000);
      // an edge arriving on the clear's clock edge stays pending
      @(negedge clk);
      src_in[21] = 1'b1;
      bus_addr = A_ECLR; bus_wdata = 32'h0020_0000; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
      rd(A_PEND, d); check("R8 set wins over clear", d, 32'h0020_0000);
      wr(A_ECLR, 32'h0020_0000);
      rd(A_PEND, d); check("R8 later clear", d, 32'h0);
   endtask

   task automatic t_route;
      logic [31:0] d;
      set_src(20, 1'b1);
      wr(A_ENS, 32'h0010_0000);
      check("R5 irq raised", {30'h0, irq_o, fiq_o}, 32'h2);
      rd(A_IRQ, d); check("R5 irq status", d, 32'h0010_0000);
      wr(A_ROUTE, 32'h0010_0000);
      check("R5 fiq raised", {30'h0, irq_o, fiq_o}, 32'h1);
      rd(A_FIQ, d); check("R5 fiq status", d, 32'h0010_0000);
      rd(A_IRQ, d); check("R5 irq status empty", d, 32'h0);
      wr(A_ENC, 32'h0010_0000);
      check("R5 R4 disabled", {30'h0, irq_o, fiq_o}, 32'h0);
      wr(A_ROUTE, 32'h0);
      wr(A_ECLR, 32'h0010_0000);
      set_src(20, 1'b0);
   endtask

   task automatic t_route_halves;
      logic [31:0] d;
      wr(A_ROUTE + 8'h4, 32'hA5A5_A5A5);
      wr(A_ROUTE, 32'h1234_5678);
      rd(A_ROUTE + 8'h4, d); check("R3 upper kept", d, 32'hA5A5_A5A5);
      rd(A_ROUTE, d);        check("R2 lower word", d, 32'h1234_5678);
      wr(A_ROUTE + 8'h4, 32'h0);
      rd(A_ROUTE, d);        check("R3 lower kept", d, 32'h1234_5678);
      wr(A_ROUTE, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] d;
      wr(A_ENS, 32'hF0);
      wr(A_ENS, 32'h0F);
      rd(A_ENS, d); check("R4 set ORs", d, 32'hFF);
      wr(A_ENC, 32'h3C);
      rd(A_ENC, d); check("R4 clear", d, 32'hC3);
      wr(A_ENS + 8'h4, 32'h1);
      rd(A_ENS + 8'h4, d); check("R4 R2 upper set", d, 32'h1);
      rd(A_ENS, d);        check("R2 lower untouched", d, 32'hC3);
      wr(A_ENC, 32'hFFFF_FFFF);
      wr(A_ENC + 8'h4, 32'hFFFF_FFFF);
      rd(A_ENS, d); check("R4 all cleared", d, 32'h0);
   endtask

   task automatic t_polarity;
      logic [31:0] d;
      wr(A_POL + 8'h4, 32'h0);
      rd(A_POL + 8'h4, d); check("R9 only top four written", d, 32'h0FFF_FFFF);
      wr(A_POL, 32'h0);
      rd(A_POL, d);        check("R9 lower write ignored", d, 32'hFFFF_FFFD);
      wr(A_POL + 8'h4, 32'hFFFF_FFFF);
      rd(A_POL + 8'h4, d); check("R9 top four set", d, 32'hFFFF_FFFF);
      wr(A_POL + 8'h4, 32'hBFFF_FFFF);
      rd(A_POL + 8'h4, d); check("R9 restored", d, 32'hBFFF_FFFF);
   endtask

   task automatic t_legacy;
      logic [31:0] d;
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h50, 32'h0);
      wr(8'h7C, 32'hFFFF_FFFF);
      rd(A_ROUTE, d);       check("R10 route unchanged", d, 32'h0);
      rd(A_ENS, d);         check("R10 enable unchanged", d, 32'h0);
      rd(A_POL + 8'h4, d);  check("R10 polarity unchanged", d, 32'hBFFF_FFFF);
      check("R10 no request", {30'h0, irq_o, fiq_o}, 32'h0);
   endtask

   task automatic t_readonly;
      logic [31:0] d;
      set_src(22, 1'b1);
      wr(A_IRQ, 32'hFFFF_FFFF);
      wr(A_FIQ, 32'hFFFF_FFFF);
      wr(A_PEND, 32'hFFFF_FFFF);
      wr(A_SENSE, 32'h0);
      wr(A_DUAL + 8'h4, 32'h0);
      wr(A_ESTAT, 32'h0);
      wr(A_SWS, 32'hFFFF_FFFF);
      wr(A_SWC, 32'hFFFF_FFFF);
      wr(8'hE8, 32'hFFFF_FFFF);
      wr(8'hF0, 32'hFFFF_FFFF);
      rd(A_PEND, d);        check("R11 pending unchanged", d, 32'h0040_0000);
      rd(A_SENSE, d);       check("R11 sense unchanged", d, 32'h0000_FFFF);
      rd(A_DUAL + 8'h4, d); check("R11 dual unchanged", d, 32'h8000_0000);
      rd(A_ENS, d);         check("R11 enable unchanged", d, 32'h0);
      rd(A_ROUTE, d);       check("R11 route unchanged", d, 32'h0);
      check("R11 no request", {30'h0, irq_o, fiq_o}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_level();
      t_edge();
      t_route();
      t_route_halves();
      t_enable();
      t_polarity();
      t_legacy();
      t_readonly();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule